// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Mode Handling

This block is a watchdog that asks for a system reset when software stops servicing it. Software writes an 8-bit control word. The top bit arms the watchdog, and the low seven bits load a down-counter. Once the watchdog is armed, the counter drops by one on every enabled clock. A reset request fires when the counter's bit 6 goes from one to zero, which means its value has fallen below 0x40. Software avoids this by rewriting the control word before that point.

The block also follows the chip's low-power states. A wait indication changes nothing. A halt request has two possible outcomes, set by a configuration input:
- If the watchdog is armed and that input is set, the halt turns straight into a reset request.
- In every other case the block freezes until an external wake-up interrupt arrives. After the wake-up it waits a fixed number of enabled clocks before the counter starts moving again.

A clock-enable input stands in for the oscillator, so the whole block stays synchronous to a single clock.

Top module: `wdog_lp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wd_active` is 0, `cnt_val` is 0x7F, `wd_frozen` is 0 and `sys_rst_req` is 0.
- R2: A write (`ctl_wr`=1) always loads `ctl_wdata[6:0]` into the counter. This load takes priority over decrementing. `ctl_wdata[7]`=1 sets the activation bit.
- R3: A write with `ctl_wdata[7]`=0 never clears an activation bit that is already set. Only `rst` clears it.
- R4: When the block is armed, not frozen, `osc_en`=1 and there is no write, the counter drops by exactly 1 per cycle. When the block is not armed, the counter holds.
- R5: `sys_rst_req` is a one-cycle pulse. Outside halt handling, it is raised on the edge where the armed counter's bit 6 falls, whether by a decrement from 0x40 or by a write of a value below 0x40. It is never raised while the block is not armed.
- R6: `wait_mode` has no effect on counting or on reset requests.
- R7: With `osc_en`=0 and no write, the counter holds its value.
- R8: A `halt_req` pulse while not frozen, with `halt_rst_opt`=1 and the block armed, raises `sys_rst_req` on the next edge and does not freeze the block.
- R9: In every other case, a `halt_req` while not frozen sets `wd_frozen`. The counter then holds and no reset request is raised, whatever `osc_en` does, until `wake_irq` or `rst`.
- R10: A `wake_irq` received while halted starts a resume delay of RESUME_CYC (default 4096) enabled clocks. `wd_frozen` drops on the RESUME_CYC-th edge after the wake-up, and the first decrement comes on the edge after that.
- R11: During the resume delay, writes load the counter, but there is no decrement and no reset request, even when bit 6 is cleared.
- R12: `rst` applied while halted brings back the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Clock enable modelling a running oscillator |
| wait_mode | input | 1 | Wait-state indication (no effect) |
| halt_req | input | 1 | One-cycle halt request |
| wake_irq | input | 1 | External wake-up interrupt |
| halt_rst_opt | input | 1 | 1: halt while armed causes reset; 0: halt freezes |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Bit 7 arm, bits 6:0 counter load value |
| sys_rst_req | output | 1 | One-cycle system reset request |
| cnt_val | output | 7 | Current counter value |
| wd_active | output | 1 | Activation bit |
| wd_frozen | output | 1 | High while halted or in the resume delay |

## Verification
The assertions check, on every cycle:
- the per-cycle step while counting, with `wait_mode` set (R6);
- the hold when the clock enable is low and while frozen;
- that the activation bit is sticky;
- that no request is raised while the block is not armed or while it stays frozen;
- the reset-on-halt response.

Only the bench scenarios can show the exact length of the resume delay, since no cycle-local property covers it. The same holds for the edge-triggered nature of expiry (a request once, not every cycle below 0x40), and for the recovery of the reset state from inside halt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_CNT_W = 7;
    localparam int WD_CTL_W = WD_CNT_W + 1;

    typedef enum logic [1:0] {
        LP_RUN    = 2'd0,
        LP_HALT   = 2'd1,
        LP_RESUME = 2'd2
    } lp_mode_e;

    typedef struct packed {
        logic                arm;
        logic [WD_CNT_W-1:0] load;
    } wd_ctl_t;

    function automatic wd_ctl_t decode_ctl(input logic [WD_CTL_W-1:0] raw);
        wd_ctl_t c;
        c.arm  = raw[WD_CTL_W-1];
        c.load = raw[WD_CNT_W-1:0];
        return c;
    endfunction

    // Bit 6 of the counter falling while armed marks expiry; activation
    // with an already-low bit 6 also counts as a fall.
    function automatic logic msb_falls(input logic act_q, input logic msb_q,
                                       input logic act_d, input logic msb_d);
        return act_d && !msb_d && (msb_q || !act_q);
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  wd_ctl_t          ctl,
    input  logic             count_ok,
    output logic             act_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             act_d,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};

    always_comb begin
        act_d = act_q | (ctl_wr & ctl.arm);
        if (ctl_wr)
            cnt_d = ctl.load;
        else if (act_q && count_ok)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= CNT_INIT;
        end else begin
            act_q <= act_d;
            cnt_q <= cnt_d;
        end
    end

    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (rst)
        act_q |=> act_q); // R3

endmodule

// File: rtl/wdog_lp_fsm.sv
module wdog_lp_fsm
    import wdog_pkg::*;
#(
    parameter int RESUME_CYC = 4096
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     osc_en,
    input  logic     halt_req,
    input  logic     wake_irq,
    input  logic     halt_rst_opt,
    input  logic     wd_active,
    output lp_mode_e mode_q,
    output logic     count_ok,
    output logic     halt_kill
);

    localparam int DLY_W = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1;
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RESUME_CYC - 1);

    lp_mode_e         mode_d;
    logic [DLY_W-1:0] dly_q, dly_d;
    logic             halt_seen;

    assign halt_seen = (mode_q == LP_RUN) && halt_req;
    assign halt_kill = halt_seen && halt_rst_opt && wd_active;
    assign count_ok  = (mode_q == LP_RUN) && osc_en;

    always_comb begin
        mode_d = mode_q;
        dly_d  = dly_q;
        unique case (mode_q)
            LP_RUN: begin
                if (halt_seen && !halt_kill)
                    mode_d = LP_HALT;
            end
            LP_HALT: begin
                if (wake_irq) begin
                    mode_d = LP_RESUME;
                    dly_d  = '0;
                end
            end
            LP_RESUME: begin
                if (osc_en) begin
                    if (dly_q == DLY_LAST)
                        mode_d = LP_RUN;
                    else
                        dly_d = dly_q + 1'b1;
                end
            end
            default: mode_d = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LP_RUN;
            dly_q  <= '0;
        end else begin
            mode_q <= mode_d;
            dly_q  <= dly_d;
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LP_HALT && !wake_irq) |=> (mode_q == LP_HALT)); // R9

    AST_RESUME_FROM_HALT: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q == LP_RESUME) |-> ($past(mode_q) == LP_HALT)); // R10

endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chk_en,
    input  logic act_q,
    input  logic msb_q,
    input  logic act_d,
    input  logic msb_d,
    input  logic halt_kill,
    output logic req_q
);

    logic req_d;

    assign req_d = halt_kill || (chk_en && msb_falls(act_q, msb_q, act_d, msb_d));

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= req_d;
    end

endmodule

// File: rtl/wdog_lp.sv
module wdog_lp
    import wdog_pkg::*;
#(
    parameter int RESUME_CYC = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                osc_en,
    input  logic                wait_mode,
    input  logic                halt_req,
    input  logic                wake_irq,
    input  logic                halt_rst_opt,
    input  logic                ctl_wr,
    input  logic [WD_CTL_W-1:0] ctl_wdata,
    output logic                sys_rst_req,
    output logic [WD_CNT_W-1:0] cnt_val,
    output logic                wd_active,
    output logic                wd_frozen
);

    localparam int CNT_W = WD_CNT_W;
    localparam int MSB   = CNT_W - 1;

    wd_ctl_t          ctl;
    lp_mode_e         mode;
    logic             count_ok, halt_kill;
    logic             act_q, act_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign ctl = decode_ctl(ctl_wdata);

    wdog_lp_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .osc_en       (osc_en),
        .halt_req     (halt_req),
        .wake_irq     (wake_irq),
        .halt_rst_opt (halt_rst_opt),
        .wd_active    (act_q),
        .mode_q       (mode),
        .count_ok     (count_ok),
        .halt_kill    (halt_kill)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl      (ctl),
        .count_ok (count_ok),
        .act_q    (act_q),
        .cnt_q    (cnt_q),
        .act_d    (act_d),
        .cnt_d    (cnt_d)
    );

    wdog_expiry u_exp (
        .clk       (clk),
        .rst       (rst),
        .chk_en    (mode == LP_RUN),
        .act_q     (act_q),
        .msb_q     (cnt_q[MSB]),
        .act_d     (act_d),
        .msb_d     (cnt_d[MSB]),
        .halt_kill (halt_kill),
        .req_q     (sys_rst_req)
    );

    assign cnt_val   = cnt_q;
    assign wd_active = act_q;
    assign wd_frozen = (mode != LP_RUN);

    AST_NO_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wd_active |-> !sys_rst_req); // R5

    AST_WAIT_BLIND: assert property (@(posedge clk) disable iff (rst)
        (wd_active && !wd_frozen && osc_en && wait_mode && !ctl_wr)
        |=> (cnt_val == CNT_W'($past(cnt_val) - 1'b1))); // R6

    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !ctl_wr) |=> $stable(cnt_val)); // R7

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wd_frozen && !ctl_wr) |=> $stable(cnt_val)); // R9

    AST_HALT_KILL: assert property (@(posedge clk) disable iff (rst)
        (halt_req && halt_rst_opt && wd_active && !wd_frozen)
        |=> (sys_rst_req && !wd_frozen)); // R8

    AST_QUIET_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (wd_frozen && $past(wd_frozen)) |-> !sys_rst_req); // R11

endmodule

// File: tb/wdog_lp_bench.sv
module wdog_lp_bench;

    logic       clk = 1'b0;
    logic       rst, osc_en, wait_mode, halt_req, wake_irq, halt_rst_opt, ctl_wr;
    logic [7:0] ctl_wdata;
    logic       sys_rst_req, wd_active, wd_frozen;
    logic [6:0] cnt_val;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    wdog_lp u_wdog_lp (
        .clk          (clk),
        .rst          (rst),
        .osc_en       (osc_en),
        .wait_mode    (wait_mode),
        .halt_req     (halt_req),
        .wake_irq     (wake_irq),
        .halt_rst_opt (halt_rst_opt),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .sys_rst_req  (sys_rst_req),
        .cnt_val      (cnt_val),
        .wd_active    (wd_active),
        .wd_frozen    (wd_frozen)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic       en;
        logic       wt;
        logic       e_act;
        logic [6:0] e_cnt;
        logic       e_req;
    } vec_t;

    localparam int NV = 13;
    localparam logic [19:0] VECS [NV] = '{
        {1'b1, 8'h45, 1'b1, 1'b0, 1'b0, 7'h45, 1'b0},  // R2 load, not armed
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 7'h45, 1'b0},  // R4 unarmed hold
        {1'b1, 8'hC2, 1'b1, 1'b0, 1'b1, 7'h42, 1'b0},  // R2 arm + load
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 7'h41, 1'b0},  // R4 step
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 7'h40, 1'b0},  // R6 wait ignored
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 7'h40, 1'b0},  // R7 enable low
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 7'h3F, 1'b1},  // R5 expiry by step
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 7'h3E, 1'b0},  // R5 single pulse
        {1'b1, 8'h7F, 1'b1, 1'b0, 1'b1, 7'h7F, 1'b0},  // R3 arm not cleared
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 7'h7E, 1'b0},  // R6 wait ignored
        {1'b1, 8'hB0, 1'b1, 1'b0, 1'b1, 7'h30, 1'b1},  // R5 expiry by write
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 7'h2F, 1'b0},  // R5 no repeat
        {1'b1, 8'hFF, 0'b0 == 0 ? 1'b1 : 1'b1, 1'b0, 1'b1, 7'h7F, 1'b0}  // R2 refresh
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seen;
        rst = 1'b1; osc_en = 1'b1; wait_mode = 1'b0; halt_req = 1'b0;
        wake_irq = 1'b0; halt_rst_opt = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00;
        @(negedge clk);
        step();
        step();
        chk("R1 active", wd_active, 0);
        chk("R1 count", cnt_val, 7'h7F);
        chk("R1 frozen", wd_frozen, 0);
        chk("R1 request", sys_rst_req, 0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            ctl_wr = v.wr; ctl_wdata = v.data; osc_en = v.en; wait_mode = v.wt;
            step();
            chk($sformatf("vec%0d active", i), wd_active, v.e_act);
            chk($sformatf("vec%0d count", i), cnt_val, v.e_cnt);
            chk($sformatf("vec%0d request", i), sys_rst_req, v.e_req);
        end
        ctl_wr = 1'b0; wait_mode = 1'b0; osc_en = 1'b1;

        // R8: reset on halt
        do_reset();
        ctl_wr = 1'b1; ctl_wdata = 8'hE0;
        step();
        ctl_wr = 1'b0; halt_req = 1'b1; halt_rst_opt = 1'b1;
        step();
        halt_req = 1'b0;
        chk("R8 request", sys_rst_req, 1);
        chk("R8 not frozen", wd_frozen, 0);
        step();
        chk("R8 pulse ends", sys_rst_req, 0);

        // R9: halt freezes
        do_reset();
        halt_rst_opt = 1'b0;
        ctl_wr = 1'b1; ctl_wdata = 8'hD0;
        step();
        ctl_wr = 1'b0; halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        chk("R9 frozen", wd_frozen, 1);
        chk("R9 count", cnt_val, 7'h4F);
        seen = 0;
        osc_en = 1'b0;
        for (int i = 0; i < 20; i++) begin step(); if (sys_rst_req) seen++; end
        osc_en = 1'b1;
        for (int i = 0; i < 20; i++) begin step(); if (sys_rst_req) seen++; end
        chk("R9 held count", cnt_val, 7'h4F);
        chk("R9 still frozen", wd_frozen, 1);
        chk("R9 no request", seen, 0);

        // R10/R11: wake and resume delay
        wake_irq = 1'b1;
        step();
        wake_irq = 1'b0;
        chk("R10 frozen after wake", wd_frozen, 1);
        repeat (10) step();
        ctl_wr = 1'b1; ctl_wdata = 8'hB5;
        step();
        ctl_wr = 1'b0;
        chk("R11 load in delay", cnt_val, 7'h35);
        chk("R11 no request", sys_rst_req, 0);
        step();
        chk("R11 no decrement", cnt_val, 7'h35);
        chk("R11 still no request", sys_rst_req, 0);
        ctl_wr = 1'b1; ctl_wdata = 8'hCF;
        step();
        ctl_wr = 1'b0;
        seen = 0;
        for (int i = 0; i < 4082; i++) begin step(); if (sys_rst_req) seen++; end
        chk("R10 frozen at end of delay", wd_frozen, 1);
        chk("R10 count held", cnt_val, 7'h4F);
        chk("R11 quiet delay", seen, 0);
        step();
        chk("R10 delay released", wd_frozen, 0);
        chk("R10 count before resume", cnt_val, 7'h4F);
        step();
        chk("R10 first decrement", cnt_val, 7'h4E);

        // R12: reset while halted
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        chk("R12 halted", wd_frozen, 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 active", wd_active, 0);
        chk("R12 count", cnt_val, 7'h7F);
        chk("R12 frozen", wd_frozen, 0);
        step();
        chk("R4 unarmed after reset", cnt_val, 7'h7F);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule